// File: doc/BRIEF.md
# Six-output commutation PWM generator

This block produces one pulse-width-modulated waveform for a three-phase brushless motor bridge and copies it to six output pins. An 8-bit counter is compared against a compare register. A period register sets the highest count (TOP). The counter runs in one of two ways. In single-slope mode it counts up and then wraps to zero. In dual-slope mode it counts up to TOP and then back down to zero. Every pin has its own override-enable bit. When that bit is clear, the pin shows a software-chosen port value in place of the waveform. Commutation firmware uses this to pick which bridge legs switch and what level the idle legs hold.

Configuration goes through a simple write port: an address, a data byte and a write strobe. The compare and TOP values are double-buffered. New values wait for the next period boundary, so a period is never cut short or glitched. An overflow flag marks each period boundary. When interrupts are enabled, the flag is also presented on an interrupt output, so that software can update the compare value.

Top module: `pwm6_gen`

## Requirements
- R1: After reset, all six pins, the overflow flag and the interrupt output are 0. The counter starts at 0 counting up, the active compare is 0 and the active TOP is 255.
- R2: In single-slope mode (control bit 0 = 0), the counter runs 0,1,…,TOP and then returns to 0. The overflow flag becomes 1 on the cycle the counter returns to 0, which is once every TOP+1 cycles.
- R3: In single-slope mode with a non-inverting setting, the waveform becomes 1 on the cycle after the counter equals compare. It becomes 0 on the cycle after the counter equals TOP. When both happen together the return to 0 wins, so compare = TOP gives a constant 0.
- R4: In dual-slope mode (control bit 0 = 1), the counter runs 0,1,…,TOP,TOP−1,…,0 with a period of 2·TOP cycles. The overflow flag becomes 1 on the cycle after the counter reaches 0 while counting down.
- R5: In dual-slope mode with a non-inverting setting, the waveform becomes 1 on the cycle after a compare match while counting up. It becomes 0 on the cycle after a compare match while counting down.
- R6: Control bits 2:1 select the output polarity. 00 disconnects the waveform so that every pin shows its port bit. 10 and 01 are non-inverting. 11 drives the complement of the waveform.
- R7: When override-enable bit i is 0, pin i shows port bit i. Each pin is chosen on its own. A change to either register appears at the pins on the clock cycle after the write, with no wait for a period boundary.
- R8: Writes to compare and TOP are buffered. They take effect from the next period boundary: the return to 0 in single-slope mode, or the arrival at 0 counting down in dual-slope mode. The period in progress keeps the old values.
- R9: Writing a 1 to bit 0 at the flag address clears the overflow flag. Writing a 0 there leaves the flag unchanged. A boundary in the same cycle as a clear leaves the flag set.
- R10: The interrupt output equals the overflow flag gated by the interrupt-enable bit (control bit 3).
- R11: The register addresses are: 0 = compare, 1 = TOP, 2 = control, 3 = override enables (bits 5:0), 4 = port values (bits 5:0), 5 = flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_pins | output | 6 | The six bridge drive outputs |
| ovf_flag | output | 1 | Overflow (period boundary) flag |
| irq | output | 1 | Interrupt request, the flag gated by its enable |

## Verification
The waveform is compared at every cycle over windows that span several periods, for both slope modes, and for a middle compare value, for compare equal to TOP, and for all four polarity codes. These windows separate set-on-match from clear-at-boundary ordering, and single-slope timing from dual-slope timing. A mixed override mask with a non-trivial port pattern shows that each pin is selected on its own. A compare write in the middle of a period shows the old value holding until the boundary and the new value taking over after it. Flag intervals measured with the old and then the new TOP separate buffered timing from immediate timing and single-slope periods from dual-slope periods.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  typedef enum logic [2:0] {
    A_CMP  = 3'd0,
    A_TOP  = 3'd1,
    A_CTRL = 3'd2,
    A_OE   = 3'd3,
    A_PORT = 3'd4,
    A_FLAG = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_ALT    = 2'b01,
    OM_NONINV = 2'b10,
    OM_INV    = 2'b11
  } outmode_e;
endpackage

// File: rtl/pwm6_regs.sv
module pwm6_regs
  import pwm6_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NPINS   = 6,
  parameter int TOP_RST = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] top_buf,
  output logic             dual,
  output outmode_e         outmode,
  output logic             irq_en,
  output logic [NPINS-1:0] oe,
  output logic [NPINS-1:0] port,
  output logic             flag_clr
);
  localparam logic [CNT_W-1:0] TOP_INIT = CNT_W'(TOP_RST);

  assign flag_clr = wr_en && (wr_addr == A_FLAG) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf <= '0;
      top_buf <= TOP_INIT;
      dual    <= 1'b0;
      outmode <= OM_OFF;
      irq_en  <= 1'b0;
      oe      <= '0;
      port    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CMP:  cmp_buf <= wr_data;
        A_TOP:  top_buf <= wr_data;
        A_CTRL: begin
          dual    <= wr_data[0];
          outmode <= outmode_e'(wr_data[2:1]);
          irq_en  <= wr_data[3];
        end
        A_OE:   oe   <= wr_data[NPINS-1:0];
        A_PORT: port <= wr_data[NPINS-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm6_counter.sv
module pwm6_counter #(
  parameter int CNT_W   = 8,
  parameter int TOP_RST = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual,
  input  logic [CNT_W-1:0] cmp_buf,
  input  logic [CNT_W-1:0] top_buf,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] top_act,
  output logic             boundary
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP_INIT = CNT_W'(TOP_RST);

  // Period boundary: end of the ramp (single) or bottom of the valley (dual)
  always_comb begin
    if (dual) boundary = !dir_up && (cnt == '0);
    else      boundary = (cnt >= top_act);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      dir_up  <= 1'b1;
      cmp_act <= '0;
      top_act <= TOP_INIT;
    end else begin
      if (boundary) begin
        cmp_act <= cmp_buf;
        top_act <= top_buf;
      end
      if (!dual) begin
        dir_up <= 1'b1;
        cnt    <= boundary ? '0 : cnt + ONE;
      end else if (dir_up) begin
        if (cnt >= top_act) begin
          dir_up <= 1'b0;
          cnt    <= (cnt == '0) ? '0 : cnt - ONE;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          dir_up <= 1'b1;
          cnt    <= (top_buf == '0) ? '0 : ONE;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/pwm6_wavegen.sv
module pwm6_wavegen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             boundary,
  output logic             wave
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wave <= 1'b0;
    end else if (!dual) begin
      if (boundary)             wave <= 1'b0;
      else if (cnt == cmp_act)  wave <= 1'b1;
    end else begin
      if (cnt == cmp_act)       wave <= dir_up;
    end
  end
endmodule

// File: rtl/pwm6_pinmux.sv
module pwm6_pinmux
  import pwm6_pkg::*;
#(
  parameter int NPINS = 6
) (
  input  logic             wave,
  input  outmode_e         outmode,
  input  logic [NPINS-1:0] oe,
  input  logic [NPINS-1:0] port,
  output logic [NPINS-1:0] pins
);
  logic connected;
  logic wave_pol;

  assign connected = (outmode != OM_OFF);
  assign wave_pol  = wave ^ (outmode == OM_INV);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pins[i] = (oe[i] && connected) ? wave_pol : port[i];
  end
endmodule

// File: rtl/pwm6_gen.sv
module pwm6_gen
  import pwm6_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int NPINS   = 6,
  parameter int TOP_RST = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [NPINS-1:0] pwm_pins,
  output logic             ovf_flag,
  output logic             irq
);
  logic [CNT_W-1:0] cmp_buf, top_buf, cmp_act, top_act, cnt;
  logic             dual, irq_en, flag_clr, dir_up, boundary, wave;
  outmode_e         outmode;
  logic [NPINS-1:0] oe, port;

  pwm6_regs #(.CNT_W(CNT_W), .NPINS(NPINS), .TOP_RST(TOP_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_buf(cmp_buf), .top_buf(top_buf), .dual(dual), .outmode(outmode),
    .irq_en(irq_en), .oe(oe), .port(port), .flag_clr(flag_clr)
  );

  pwm6_counter #(.CNT_W(CNT_W), .TOP_RST(TOP_RST)) u_cnt (
    .clk(clk), .rst(rst), .dual(dual), .cmp_buf(cmp_buf), .top_buf(top_buf),
    .cnt(cnt), .dir_up(dir_up), .cmp_act(cmp_act), .top_act(top_act),
    .boundary(boundary)
  );

  pwm6_wavegen #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .dual(dual), .cnt(cnt), .dir_up(dir_up),
    .cmp_act(cmp_act), .boundary(boundary), .wave(wave)
  );

  pwm6_pinmux #(.NPINS(NPINS)) u_mux (
    .wave(wave), .outmode(outmode), .oe(oe), .port(port), .pins(pwm_pins)
  );

  // Flag: a boundary outranks a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)           ovf_flag <= 1'b0;
    else if (boundary) ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;
  end

  assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/pwm6_gen_checker.sv
module pwm6_gen_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             dual,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] top_act,
  input logic             dir_up,
  input logic             boundary,
  input logic             flag_clr,
  input logic             ovf_flag,
  input logic             irq
);
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!dual && cnt >= top_act) |=> (cnt == '0));

  p_flag_on_boundary_r2: assert property (@(posedge clk) disable iff (rst)
    boundary |=> ovf_flag);

  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= top_act);

  p_dual_climb_r4: assert property (@(posedge clk) disable iff (rst)
    (dual && dir_up && cnt < top_act) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !boundary) |=> !ovf_flag);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);
endmodule

bind pwm6_gen pwm6_gen_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .dual(dual), .cnt(cnt), .top_act(top_act),
  .dir_up(dir_up), .boundary(boundary), .flag_clr(flag_clr),
  .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/pwm6_gen_test.sv
module pwm6_gen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] pwm_pins;
  logic       ovf_flag, irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  localparam logic [5:0] PAT = 6'b101101;

  pwm6_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_pins(pwm_pins), .ovf_flag(ovf_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; one clock per write
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Clear the flag, then stop at the first falling edge showing a new boundary
  task automatic sync(input string req);
    bit seen = 1'b0;
    wr(3'd5, 8'h01);
    for (int i = 0; i < 1000; i++) begin
      if (ovf_flag) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    if (!seen) chk(1'b0, req, "no boundary seen", 0, 1);
  endtask

  // Clear the flag, then count falling edges until it is set again
  task automatic flag_gap(input string req, input int exp_gap);
    int n = 0;
    wr(3'd5, 8'h01);
    chk(!ovf_flag, "R9", "flag after clear", int'(ovf_flag), 0);
    while (!ovf_flag && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_gap, req, "cycles to next flag", n, exp_gap);
  endtask

  function automatic bit wave_at(input int q, input int t, input int c, input bit dl);
    int p = dl ? 2 * t : t + 1;
    int r = q % p;
    if (dl) return (r > c) && (r <= 2 * t - c);
    return (r > c) && (r <= t);
  endfunction

  // Compare the pins on every cycle of a window; c0 holds in the first period, c1 after it
  task automatic win(input int q0, input int n, input int t, input int c0, input int c1,
                     input bit dl, input logic [1:0] om, input logic [5:0] oe,
                     input logic [5:0] port, input string req);
    int errs = 0;
    int p = dl ? 2 * t : t + 1;
    int first_act = 0, first_exp = 0;
    for (int i = 0; i < n; i++) begin
      int q = q0 + i;
      int c = (q < p) ? c0 : c1;
      bit w = wave_at(q, t, c, dl) ^ (om == 2'b11);
      logic [5:0] e;
      for (int b = 0; b < 6; b++) e[b] = (oe[b] && om != 2'b00) ? w : port[b];
      if (pwm_pins !== e) begin
        if (errs == 0) begin first_act = int'(pwm_pins); first_exp = int'(e); end
        errs++;
      end
      @(negedge clk);
    end
    chk(errs == 0, req, "pin pattern over window", first_act, first_exp);
  endtask

  task automatic t_reset;
    chk(pwm_pins == 6'h00, "R1", "pins after reset", int'(pwm_pins), 0);
    chk(!ovf_flag && !irq, "R1", "flag/irq after reset", int'({ovf_flag, irq}), 0);
  endtask

  task automatic t_port_bypass;
    wr(3'd4, {2'b00, PAT});
    chk(pwm_pins == PAT, "R7", "port value with overrides clear", int'(pwm_pins), int'(PAT));
  endtask

  task automatic t_single;
    wr(3'd0, 8'd3); wr(3'd1, 8'd9); wr(3'd2, 8'h0C); wr(3'd3, 8'h3F);
    sync("R2");
    chk(ovf_flag && irq, "R10", "irq with enable set", int'({ovf_flag, irq}), 3);
    win(0, 30, 9, 3, 3, 1'b0, 2'b10, 6'h3F, PAT, "R3");
    flag_gap("R2", 9);
    wr(3'd5, 8'h00);
    chk(ovf_flag, "R9", "write of 0 keeps flag", int'(ovf_flag), 1);
    wr(3'd2, 8'h04);
    chk(ovf_flag && !irq, "R10", "irq masked", int'({ovf_flag, irq}), 2);
  endtask

  task automatic t_polarity;
    wr(3'd2, 8'h06); sync("R6");
    win(0, 20, 9, 3, 3, 1'b0, 2'b11, 6'h3F, PAT, "R6");
    wr(3'd2, 8'h02); sync("R6");
    win(0, 20, 9, 3, 3, 1'b0, 2'b01, 6'h3F, PAT, "R6");
    wr(3'd2, 8'h00);
    win(0, 20, 9, 3, 3, 1'b0, 2'b00, 6'h3F, PAT, "R6");
  endtask

  task automatic t_override;
    wr(3'd2, 8'h04); wr(3'd3, 8'h07); sync("R7");
    win(0, 20, 9, 3, 3, 1'b0, 2'b10, 6'h07, PAT, "R7");
    wr(3'd3, 8'h00);
    chk(pwm_pins == PAT, "R7", "override off takes effect at once", int'(pwm_pins), int'(PAT));
    wr(3'd3, 8'h3F);
  endtask

  task automatic t_cmp_eq_top;
    wr(3'd0, 8'd9); sync("R3");
    win(0, 20, 9, 9, 9, 1'b0, 2'b10, 6'h3F, PAT, "R3");
  endtask

  task automatic t_buffered;
    wr(3'd0, 8'd3); sync("R8");
    wr(3'd0, 8'd6);
    win(1, 19, 9, 3, 6, 1'b0, 2'b10, 6'h3F, PAT, "R8");
    sync("R8");
    wr(3'd1, 8'd5);
    flag_gap("R8", 8);
    flag_gap("R8", 5);
  endtask

  task automatic t_dual;
    wr(3'd1, 8'd8); wr(3'd0, 8'd3); wr(3'd2, 8'h0D);
    sync("R4");
    win(1, 40, 8, 3, 3, 1'b1, 2'b10, 6'h3F, PAT, "R5");
    sync("R4");
    flag_gap("R4", 15);
    sync("R8");
    wr(3'd0, 8'd5);
    win(2, 30, 8, 3, 5, 1'b1, 2'b10, 6'h3F, PAT, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_port_bypass();
    t_single();
    t_polarity();
    t_override();
    t_cmp_eq_top();
    t_buffered();
    t_dual();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..R11 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule